// File: doc/BRIEF.md
# Byte-Accessed Bidirectional Tick Counter

This block holds a 16-bit count that software reaches over a narrow 8-bit bus. Two byte addresses expose the count. A single shared staging byte sits behind the high-byte address and makes every 16-bit transfer atomic. Reading the low byte captures the matching high byte into the staging byte on the same edge, so a later read of the high address returns a coherent half. Writing the low byte commits the staging byte and the new low byte to the count together.

On the timer side, a 3-bit select field picks one of seven external tick enables, and the value 0 stops the count. Outside control logic supplies three controls: step, direction and clear. On each selected tick the count clears or moves by one, and it wraps modulo 2^16. Two registered flags follow the count: one marks the all-ones value and one marks zero. An overflow flag is set by an external strobe and doubles as the interrupt request. Software clears it by writing a 1, and it also clears when the interrupt is acknowledged.

Top module: `byte_tick_counter`

## Requirements
- R1: A synchronous active-high reset sets the count, the staging byte, the overflow flag and the read data to zero. After reset, at_bottom is 1 and at_top is 0.
- R2: The bus address is 2 bits: 0 is the low count byte, 1 is the high (staging) byte and 2 is the flag byte. A read at address 1 returns the staging byte. A write at address 1 loads only the staging byte and leaves the count unchanged. rd_data is registered: it updates on the edge where rd_en is sampled and holds its value otherwise.
- R3: A read at address 0 returns count[7:0]. On the same edge it copies count[15:8], taken before any update on that edge, into the staging byte.
- R4: A write at address 0 loads the whole count with {staging byte, wr_data} on a single edge.
- R5: When tick_sel is 0 the count does not move on its own. When tick_sel is k (1..7), tick_src[k-1] is the tick enable.
- R6: On a tick with cnt_clear=1 the count becomes 0, whatever cnt_step is. On a tick with cnt_clear=0 and cnt_step=1 the count rises by one if cnt_down=0 and falls by one if cnt_down=1. With neither control set the count holds.
- R7: A write at address 0 takes priority over clear and step in the same cycle.
- R8: Count arithmetic wraps: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R9: at_top is 1 exactly when the count is 0xFFFF, and at_bottom is 1 exactly when the count is 0. Both change on the same edge as the count.
- R10: ovf_irq is set on the edge after ovf_set=1. It clears after ovf_ack=1, or after a write at address 2 with wr_data[0]=1. A set in the same cycle wins over a clear. A read at address 2 returns {7'b0, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Byte address: 0 low, 1 high/staging, 2 flag |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| tick_sel | input | 3 | Tick source select, 0 stops |
| tick_src | input | 7 | Candidate tick enables |
| cnt_step | input | 1 | Step on tick |
| cnt_down | input | 1 | 1 counts down, 0 counts up |
| cnt_clear | input | 1 | Clear on tick |
| ovf_set | input | 1 | Overflow flag set strobe |
| ovf_ack | input | 1 | Interrupt acknowledge |
| at_top | output | 1 | Count is all ones |
| at_bottom | output | 1 | Count is zero |
| ovf_irq | output | 1 | Overflow flag / interrupt request |

## Verification
If the count register is corrupted, at_top and at_bottom disagree with the model on the next edge whenever the count is at either end. The corruption also appears in rd_data one cycle after any read at address 0. If the staging byte is wrong, rd_data is wrong after the next read at address 1. A wrong staging byte also corrupts the high half of the count on the next write at address 0, which a later read shows. If the overflow flag is wrong, ovf_irq shows it on the very edge after the faulty set or clear.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int unsigned ADR_W = 2;
  typedef enum logic [ADR_W-1:0] {
    ADR_LOW  = 2'd0,
    ADR_HIGH = 2'd1,
    ADR_FLAG = 2'd2
  } bus_reg_e;
endpackage

// File: rtl/btc_tick_mux.sv
module btc_tick_mux #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NSRC = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src,
  output logic             tick
);
  // select code 0 maps to a constant-zero input: counter stopped
  logic [NSRC:0] padded;
  assign padded = {src, 1'b0};
  assign tick   = padded[sel];
endmodule

// File: rtl/btc_count_core.sv
module btc_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             step,
  input  logic             down,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             top,
  output logic             bottom
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = cnt;
    if (load)              nxt = load_val;
    else if (tick && clr)  nxt = '0;
    else if (tick && step) nxt = down ? cnt - ONE : cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      top    <= 1'b0;
      bottom <= 1'b1;
    end else begin
      cnt    <= nxt;
      top    <= (nxt == ALL_ONES);
      bottom <= (nxt == '0);
    end
  end
endmodule

// File: rtl/btc_bus_port.sv
module btc_bus_port
  import btc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADR_W-1:0]  addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] stage,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              flag_wclr
);
  logic hit_low, hit_high, hit_flag;

  assign hit_low  = (addr == ADR_LOW);
  assign hit_high = (addr == ADR_HIGH);
  assign hit_flag = (addr == ADR_FLAG);

  assign load      = wr && hit_low;
  assign load_val  = {stage, wdata};
  assign flag_wclr = wr && hit_flag && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else if (wr && hit_high) begin
      stage <= wdata;
    end else if (rd && hit_low) begin
      stage <= cnt[CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_low)       rdata <= cnt[BYTE_W-1:0];
      else if (hit_high) rdata <= stage;
      else if (hit_flag) rdata <= {{(BYTE_W-1){1'b0}}, flag};
      else               rdata <= '0;
    end
  end
endmodule

// File: rtl/btc_ovf_flag.sv
module btc_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic wclr,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)              flag <= 1'b0;
    else if (set)         flag <= 1'b1;
    else if (wclr || ack) flag <= 1'b0;
  end
endmodule

// File: rtl/byte_tick_counter.sv
module byte_tick_counter
  import btc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned CNT_W = 2 * BYTE_W,
  localparam int unsigned NSRC  = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [SEL_W-1:0]  tick_sel,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              cnt_step,
  input  logic              cnt_down,
  input  logic              cnt_clear,
  input  logic              ovf_set,
  input  logic              ovf_ack,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_irq
);
  logic              tick_w;
  logic              load_w;
  logic [CNT_W-1:0]  load_val_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [BYTE_W-1:0] stage_w;
  logic              wclr_w;

  btc_tick_mux #(.SEL_W(SEL_W)) u_mux (
    .sel  (tick_sel),
    .src  (tick_src),
    .tick (tick_w)
  );

  btc_bus_port #(.BYTE_W(BYTE_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .rd        (rd_en),
    .wr        (wr_en),
    .wdata     (wr_data),
    .cnt       (cnt_w),
    .flag      (ovf_irq),
    .rdata     (rd_data),
    .stage     (stage_w),
    .load      (load_w),
    .load_val  (load_val_w),
    .flag_wclr (wclr_w)
  );

  btc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .clr      (cnt_clear),
    .step     (cnt_step),
    .down     (cnt_down),
    .load     (load_w),
    .load_val (load_val_w),
    .cnt      (cnt_w),
    .top      (at_top),
    .bottom   (at_bottom)
  );

  btc_ovf_flag u_ovf (
    .clk  (clk),
    .rst  (rst),
    .set  (ovf_set),
    .wclr (wclr_w),
    .ack  (ovf_ack),
    .flag (ovf_irq)
  );
endmodule

// File: rtl/btc_checker.sv
module btc_checker
  import btc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADR_W-1:0]  bus_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic [SEL_W-1:0]  tick_sel,
  input logic              ovf_set,
  input logic              ovf_ack,
  input logic              at_top,
  input logic              at_bottom,
  input logic              ovf_irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [BYTE_W-1:0] stage
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (at_bottom && !at_top && !ovf_irq && cnt == '0 && stage == '0));

  // R9
  ends_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(at_top && at_bottom));

  // R4
  atomic_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == ADR_LOW) |=> (cnt == {$past(stage), $past(wr_data)}));

  // R3
  stage_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && bus_addr == ADR_LOW) |=> (stage == $past(cnt[CNT_W-1:BYTE_W])));

  // R5
  stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_sel == '0 && !(wr_en && bus_addr == ADR_LOW)) |=> $stable(cnt));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf_irq);

  // R10
  flag_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_ack && !ovf_set) |=> !ovf_irq);
endmodule

bind byte_tick_counter btc_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .tick_sel  (tick_sel),
  .ovf_set   (ovf_set),
  .ovf_ack   (ovf_ack),
  .at_top    (at_top),
  .at_bottom (at_bottom),
  .ovf_irq   (ovf_irq),
  .cnt       (cnt_w),
  .stage     (stage_w)
);

// File: tb/sim_byte_tick_counter.sv
`timescale 1ns/1ps
module sim_byte_tick_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [2:0] tick_sel = 3'd0;
  logic [6:0] tick_src = 7'd0;
  logic       cnt_step = 1'b0, cnt_down = 1'b0, cnt_clear = 1'b0;
  logic       ovf_set = 1'b0, ovf_ack = 1'b0;
  logic       at_top, at_bottom, ovf_irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  int m_cnt = 0, m_stg = 0, m_flag = 0, m_rd = 0;

  always #5 clk = ~clk;

  byte_tick_counter u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_sel(tick_sel), .tick_src(tick_src),
    .cnt_step(cnt_step), .cnt_down(cnt_down), .cnt_clear(cnt_clear),
    .ovf_set(ovf_set), .ovf_ack(ovf_ack), .at_top(at_top), .at_bottom(at_bottom),
    .ovf_irq(ovf_irq)
  );

  always @(posedge clk) begin
    int n_cnt, n_stg, n_flag, n_rd;
    bit tk;
    if (rst) begin
      m_cnt = 0; m_stg = 0; m_flag = 0; m_rd = 0;
    end else begin
      tk = (tick_sel != 0) && tick_src[tick_sel-1];
      n_cnt = m_cnt; n_stg = m_stg; n_flag = m_flag; n_rd = m_rd;
      if (rd_en) begin
        if (bus_addr == 0)      n_rd = m_cnt % 256;
        else if (bus_addr == 1) n_rd = m_stg;
        else if (bus_addr == 2) n_rd = m_flag;
        else                    n_rd = 0;
      end
      if (wr_en && bus_addr == 1)      n_stg = wr_data;
      else if (rd_en && bus_addr == 0) n_stg = m_cnt / 256;
      if (wr_en && bus_addr == 0)  n_cnt = m_stg * 256 + wr_data;
      else if (tk && cnt_clear)    n_cnt = 0;
      else if (tk && cnt_step)     n_cnt = cnt_down ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
      if (ovf_set) n_flag = 1;
      else if (ovf_ack || (wr_en && bus_addr == 2 && wr_data[0])) n_flag = 0;
      m_cnt = n_cnt; m_stg = n_stg; m_flag = n_flag; m_rd = n_rd;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #2;
    check("R2/R3 rd_data", rd_data, m_rd);
    check("R9 at_top", at_top, m_cnt == 65535);
    check("R9 at_bottom", at_bottom, m_cnt == 0);
    check("R10 ovf_irq", ovf_irq, m_flag);
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; ovf_set = 0; ovf_ack = 0;
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; wr_data = d; wr_en = 1; rd_en = 0;
    cycle(); idle();
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; rd_en = 1; wr_en = 0;
    cycle(); d = rd_data; idle();
  endtask

  task automatic read16(output int v);
    logic [7:0] lo, hi;
    bread(2'd0, lo);
    bread(2'd1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic load16(input int v);
    bwrite(2'd1, v[15:8]);
    bwrite(2'd0, v[7:0]);
  endtask

  initial begin
    int v;
    logic [7:0] b;
    repeat (2) @(posedge clk);
    #2;
    // R1 reset state (rst still high across this edge)
    cycle();
    rst = 0;
    check("R1 at_bottom after reset", at_bottom, 1);
    check("R1 ovf_irq after reset", ovf_irq, 0);
    read16(v); check("R1 count after reset", v, 0);

    // R2 / R3 / R4 atomic load and readback
    load16(16'hABCD);
    read16(v); check("R4 loaded count", v, 16'hABCD);
    bwrite(2'd1, 8'h55);
    bread(2'd1, b); check("R2 staging readback", b, 8'h55);
    read16(v); check("R2 high write leaves count", v, 16'hABCD);

    // R6 up count via source 0
    tick_sel = 3'd1; tick_src = 7'b0000001; cnt_step = 1; cnt_down = 0;
    repeat (5) cycle();
    tick_sel = 0; read16(v); check("R6 up by five", v, 16'hABD2);
    // R6 down
    tick_sel = 3'd1; cnt_down = 1;
    repeat (3) cycle();
    tick_sel = 0; read16(v); check("R6 down by three", v, 16'hABCF);
    // R5 stopped and source select
    repeat (4) cycle();
    read16(v); check("R5 stopped", v, 16'hABCF);
    tick_sel = 3'd3; tick_src = 7'b0000011; cnt_down = 0;
    repeat (4) cycle();
    tick_sel = 0; read16(v); check("R5 unselected source ignored", v, 16'hABCF);
    tick_sel = 3'd3; tick_src = 7'b0000100;
    repeat (2) cycle();
    tick_sel = 0; read16(v); check("R5 source 2 selected", v, 16'hABD1);
    // R6 clear wins over step
    tick_sel = 3'd3; cnt_clear = 1; cycle(); cnt_clear = 0; tick_sel = 0;
    read16(v); check("R6 clear", v, 0);
    // R8 wrap down then up
    tick_sel = 3'd3; cnt_down = 1; cycle(); tick_sel = 0;
    check("R8 R9 at_top after wrap down", at_top, 1);
    read16(v); check("R8 wrap down", v, 16'hFFFF);
    tick_sel = 3'd3; cnt_down = 0; cycle(); tick_sel = 0;
    check("R8 R9 at_bottom after wrap up", at_bottom, 1);
    // R7 write beats tick
    bwrite(2'd1, 8'h12);
    tick_sel = 3'd3; cnt_clear = 1;
    bwrite(2'd0, 8'h34);
    cnt_clear = 0; tick_sel = 0;
    read16(v); check("R7 write priority", v, 16'h1234);
    // R3 capture survives later count change
    bread(2'd0, b); check("R3 low byte", b, 8'h34);
    tick_sel = 3'd3; repeat (300) cycle(); tick_sel = 0;
    bread(2'd1, b); check("R3 captured high byte", b, 8'h12);
    // R10 flag
    ovf_set = 1; cycle(); idle();
    check("R10 set", ovf_irq, 1);
    bread(2'd2, b); check("R10 flag read", b, 1);
    bwrite(2'd2, 8'h00); check("R10 write zero keeps", ovf_irq, 1);
    bwrite(2'd2, 8'h01); check("R10 write one clears", ovf_irq, 0);
    ovf_set = 1; ovf_ack = 1; cycle(); idle();
    check("R10 set beats ack", ovf_irq, 1);
    ovf_ack = 1; cycle(); idle();
    check("R10 ack clears", ovf_irq, 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bus_addr = 2'($urandom_range(0, 3));
      rd_en = 1'($urandom); wr_en = 1'($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      tick_sel = 3'($urandom); tick_src = 7'($urandom);
      cnt_step = 1'($urandom); cnt_down = 1'($urandom);
      cnt_clear = 1'($urandom_range(0, 15) == 0);
      ovf_set = 1'($urandom_range(0, 7) == 0);
      ovf_ack = 1'($urandom_range(0, 7) == 0);
      rst = (i == 1500);
      cycle();
    end
    rst = 0; idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule